// File: doc/BRIEF.md
# Expansion slot address decoder

This block turns a 16-bit processor address into active-low select strobes for an eight-slot peripheral backplane. Each slot gets two strobes. One covers a 16-byte register window in the shared I/O page. The other covers a 256-byte firmware page, which slot 0 does not have. A single strobe shared by all cards marks the 2 KiB expansion-ROM area.

The address settles during phase one and stays valid to the end of phase zero. The decode can therefore be resolved early and released only while phase zero is high and phase one is low. Every strobe is registered on the system clock, so the outputs show the inputs sampled at the previous rising edge.

A global active-low kill input forces every strobe to its idle high level. This lets an external agent disable all internal I/O decoding at once.

Top module: `slot_sel_decoder`

## Requirements
- R1: While rst_ni is low, every strobe (dev_sel_no, fw_sel_no, xrom_sel_no) is high, whatever the inputs are.
- R2: dev_sel_no[n] goes low for an address from 0xC000+16*(n+8) to 0xC00F+16*(n+8). In bit terms, addr[15:8]=0xC0, addr[7]=1 and addr[6:4]=n. No other address drives it low.
- R3: fw_sel_no[n] goes low for an address from 0xCn00 to 0xCnFF, for n from 1 to 7. Page 0xC0xx drives no firmware strobe, and no output for slot 0 exists.
- R4: xrom_sel_no goes low for any address from 0xC800 to 0xCFFF, and for no other address.
- R5: A strobe can go low only if phi0_i was high and phi1_i was low at the sampling edge. Otherwise every strobe is high, and this includes the case where both phases are high.
- R6: If decode_en_ni was low at the sampling edge, every strobe is high regardless of address or phase.
- R7: Outputs change only at a rising edge of clk_i. They reflect the inputs that were present at that edge, so the latency is one cycle.
- R8: At most one bit of dev_sel_no and at most one bit of fw_sel_no is low at a time. xrom_sel_no is never low together with a device or firmware strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; strobes update on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Processor address bus |
| phi0_i | input | 1 | Phase-zero clock level, used as the release qualifier |
| phi1_i | input | 1 | Phase-one clock level, which blocks release while high |
| decode_en_ni | input | 1 | Active-low global decode kill |
| dev_sel_no | output | 8 | Per-slot 16-byte register window select, active low |
| fw_sel_no | output | 7 | Firmware page select for slots 1 to 7 (bit n is slot n), active low |
| xrom_sel_no | output | 1 | Shared expansion-ROM area select, active low |

## Verification
A valid address hit and a qualifier veto can arrive in the same cycle. The veto comes either from the kill input or from the wrong clock phase, and the veto must win. The bench provokes this by sweeping the full address space with phase zero withheld, and by repeating the sweep with the kill input held low. In both runs, slot, firmware and expansion-ROM addresses all reach the decoder. Every sampled output word is compared with an all-high value computed in the bench. A second full sweep with the qualifier open confirms that the same addresses do produce the strobes that the range rules predict.

// File: rtl/slot_dec_pkg.sv
package slot_dec_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned MAX_SLOTS = 8;
  // address map tags
  localparam logic [7:0] IO_PAGE_TAG   = 8'hC0;     // 0xC000-0xC0FF
  localparam logic [4:0] CARD_BAND_TAG = 5'b11000;  // 0xC000-0xC7FF
  localparam logic [4:0] XROM_TAG      = 5'b11001;  // 0xC800-0xCFFF
endpackage

// File: rtl/slot_dec_hit.sv
module slot_dec_hit
  import slot_dec_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = MAX_SLOTS,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_SLOTS-1:0] dev_hit_o,
  output logic [NUM_SLOTS-1:1] fw_hit_o,
  output logic                 xrom_hit_o
);
  logic io_page;
  logic card_band;
  logic upper_half;
  logic unused_low;

  assign io_page    = (addr_i[15:8] == IO_PAGE_TAG);
  assign card_band  = (addr_i[15:11] == CARD_BAND_TAG);
  assign upper_half = addr_i[7];
  assign xrom_hit_o = (addr_i[15:11] == XROM_TAG);
  assign unused_low = ^addr_i[3:0];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dev
    assign dev_hit_o[s] = io_page & upper_half & (addr_i[4 +: SLOT_W] == SLOT_W'(s));
  end

  // slot 0 owns no firmware page: its page is the I/O page
  for (genvar s = 1; s < NUM_SLOTS; s++) begin : g_fw
    assign fw_hit_o[s] = card_band & (addr_i[8 +: SLOT_W] == SLOT_W'(s));
  end
endmodule

// File: rtl/slot_dec_qual.sv
module slot_dec_qual (
  input  logic phi0_i,
  input  logic phi1_i,
  input  logic decode_en_ni,
  output logic open_o
);
  // release only in clean phase zero, never on overlap, never when killed
  assign open_o = phi0_i & ~phi1_i & decode_en_ni;
endmodule

// File: rtl/slot_dec_oreg.sv
module slot_dec_oreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '1;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/slot_sel_decoder.sv
module slot_sel_decoder
  import slot_dec_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = MAX_SLOTS,
  localparam int unsigned OUT_W = 2 * NUM_SLOTS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 phi0_i,
  input  logic                 phi1_i,
  input  logic                 decode_en_ni,
  output logic [NUM_SLOTS-1:0] dev_sel_no,
  output logic [NUM_SLOTS-1:1] fw_sel_no,
  output logic                 xrom_sel_no
);
  logic [NUM_SLOTS-1:0] dev_hit;
  logic [NUM_SLOTS-1:1] fw_hit;
  logic                 xrom_hit;
  logic                 open_win;
  logic [OUT_W-1:0]     sel_d;
  logic [OUT_W-1:0]     sel_q;

  slot_dec_hit #(.NUM_SLOTS(NUM_SLOTS)) u_hit (
    .addr_i    (addr_i),
    .dev_hit_o (dev_hit),
    .fw_hit_o  (fw_hit),
    .xrom_hit_o(xrom_hit)
  );

  slot_dec_qual u_qual (
    .phi0_i      (phi0_i),
    .phi1_i      (phi1_i),
    .decode_en_ni(decode_en_ni),
    .open_o      (open_win)
  );

  assign sel_d = ~({dev_hit, fw_hit, xrom_hit} & {OUT_W{open_win}});

  slot_dec_oreg #(.W(OUT_W)) u_oreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sel_d),
    .q_o   (sel_q)
  );

  assign dev_sel_no  = sel_q[OUT_W-1 -: NUM_SLOTS];
  assign fw_sel_no   = sel_q[NUM_SLOTS-1:1];
  assign xrom_sel_no = sel_q[0];
endmodule

// File: rtl/slot_sel_decoder_chk.sv
module slot_sel_decoder_chk #(
  parameter int unsigned NUM_SLOTS = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [15:0]          addr_i,
  input logic                 phi0_i,
  input logic                 phi1_i,
  input logic                 decode_en_ni,
  input logic [NUM_SLOTS-1:0] dev_sel_no,
  input logic [NUM_SLOTS-1:1] fw_sel_no,
  input logic                 xrom_sel_no
);
  logic past_ok;
  logic all_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign all_idle = (&dev_sel_no) & (&fw_sel_no) & xrom_sel_no;

  assert_dev_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dev_sel_no));
  assert_fw_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~fw_sel_no));
  assert_xrom_alone_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xrom_sel_no |-> ((&dev_sel_no) && (&fw_sel_no)));
  assert_kill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(decode_en_ni)) |-> all_idle);
  assert_phase_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !($past(phi0_i) && !$past(phi1_i))) |-> all_idle);
  assert_dev_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !(&dev_sel_no)) |-> ($past(addr_i[15:7]) == 9'h181));
  assert_fw_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !(&fw_sel_no)) |->
      (($past(addr_i[15:11]) == 5'b11000) && ($past(addr_i[10:8]) != 3'd0)));
  assert_xrom_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !xrom_sel_no) |-> ($past(addr_i[15:11]) == 5'b11001));
endmodule

bind slot_sel_decoder slot_sel_decoder_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .phi0_i      (phi0_i),
  .phi1_i      (phi1_i),
  .decode_en_ni(decode_en_ni),
  .dev_sel_no  (dev_sel_no),
  .fw_sel_no   (fw_sel_no),
  .xrom_sel_no (xrom_sel_no)
);

// File: tb/slot_sel_decoder_tb.sv
module slot_sel_decoder_tb;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = 16'h0000;
  logic        phi0_i = 1'b0;
  logic        phi1_i = 1'b0;
  logic        decode_en_ni = 1'b1;
  logic [7:0]  dev_sel_no;
  logic [7:1]  fw_sel_no;
  logic        xrom_sel_no;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  slot_sel_decoder u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .phi0_i      (phi0_i),
    .phi1_i      (phi1_i),
    .decode_en_ni(decode_en_ni),
    .dev_sel_no  (dev_sel_no),
    .fw_sel_no   (fw_sel_no),
    .xrom_sel_no (xrom_sel_no)
  );

  // {dev[7:0], fw[7:1], xrom}
  function automatic logic [15:0] model(logic [15:0] a, logic p0, logic p1, logic en);
    logic [7:0] dev = '1;
    logic [6:0] fw = '1;
    logic       x = 1'b1;
    int unsigned ua = a;
    if (p0 && !p1 && en) begin
      if (ua >= 32'hC080 && ua <= 32'hC0FF) dev[(ua - 32'hC080) / 16] = 1'b0;
      if (ua >= 32'hC100 && ua <= 32'hC7FF) fw[(ua / 256) - 32'hC1] = 1'b0;
      if (ua >= 32'hC800 && ua <= 32'hCFFF) x = 1'b0;
    end
    return {dev, fw, x};
  endfunction

  function automatic string tag_of(logic [15:0] a, logic p0, logic p1, logic en);
    if (!en) return "R6";
    if (!(p0 && !p1)) return "R5";
    if (a >= 16'hC800 && a <= 16'hCFFF) return "R4";
    if (a >= 16'hC100 && a <= 16'hC7FF) return "R3";
    return "R2";
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] outw();
    return {dev_sel_no, fw_sel_no, xrom_sel_no};
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  // called at a negedge; returns at the next negedge after sampling
  task automatic step(logic [15:0] a, logic p0, logic p1, logic en);
    logic [15:0] got;
    logic [15:0] exp;
    addr_i = a; phi0_i = p0; phi1_i = p1; decode_en_ni = en;
    @(posedge clk_i);
    @(negedge clk_i);
    got = outw();
    exp = model(a, p0, p1, en);
    check(got == exp, tag_of(a, p0, p1, en), got, exp);
    // R8: exclusivity of strobes
    check(($countones(~got[15:8]) <= 1) && ($countones(~got[7:1]) <= 1) &&
          (got[0] || (&got[15:1])), "R8", got, exp);
  endtask

  initial begin
    #(CLK_P * 180000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R1: reset holds every strobe idle even with a hit presented
    addr_i = 16'hC0A3; phi0_i = 1'b1; phi1_i = 1'b0; decode_en_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(outw() == 16'hFFFF, "R1", outw(), 16'hFFFF);
    addr_i = 16'hC900;
    @(negedge clk_i);
    check(outw() == 16'hFFFF, "R1", outw(), 16'hFFFF);
    phi0_i = 1'b0;
    addr_i = 16'h0000;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(outw() == 16'hFFFF, "R1", outw(), 16'hFFFF);

    // R7: one-cycle latency; output stays idle until the next rising edge
    addr_i = 16'hC0A5; phi0_i = 1'b1; phi1_i = 1'b0;
    #(CLK_P/4);
    check(outw() == 16'hFFFF, "R7", outw(), 16'hFFFF);
    @(posedge clk_i);
    @(negedge clk_i);
    check(outw() == model(16'hC0A5, 1, 0, 1), "R7", outw(), model(16'hC0A5, 1, 0, 1));
    addr_i = 16'h1234;
    #(CLK_P/4);
    check(outw() == model(16'hC0A5, 1, 0, 1), "R7", outw(), model(16'hC0A5, 1, 0, 1));
    @(posedge clk_i);
    @(negedge clk_i);
    check(outw() == 16'hFFFF, "R7", outw(), 16'hFFFF);

    // R2 R3 R4: full sweep with the window open
    for (int i = 0; i < 65536; i++) step(16'(i), 1'b1, 1'b0, 1'b1);
    // R5: full sweep in phase one
    for (int i = 0; i < 65536; i++) step(16'(i), 1'b0, 1'b1, 1'b1);
    // R6: kill held low during phase zero
    for (int i = 0; i < 16384; i++) step(16'(i * 4 + ((i >> 8) & 3)), 1'b1, 1'b0, 1'b0);
    // R5: overlapping phases
    for (int i = 0; i < 4096; i++) step(16'(i * 16 + (i & 15)), 1'b1, 1'b1, 1'b1);
    // R6: kill released again restores decoding
    step(16'hC0F0, 1'b1, 1'b0, 1'b0);
    step(16'hC0F0, 1'b1, 1'b0, 1'b1);
    step(16'hC700, 1'b1, 1'b0, 1'b1);

    summary();
    $finish;
  end
endmodule